// File: doc/BRIEF.md
# DRAM Wake-Up and Refresh Scheduler

This block brings a multiplexed-address dynamic memory out of power-up and keeps its contents alive. After reset it waits a fixed settling pause. It then runs a burst of row-strobe-only wake-up cycles and only then raises `ready_o`. From that point it schedules one row-strobe-only refresh per refresh interval. Each refresh targets the next row of a 7-bit row counter, which wraps at the end. The column strobe is held inactive throughout, and the data and write lines are never driven.

The block does not own the memory pins outright. Whenever a cycle is pending it raises a request toward the memory cycle controller. It starts the cycle only in the clock where the request meets a grant. While the cycle runs, it drives the row strobe and the row address. Refresh intervals that pass while the grant is withheld are not lost: they are counted as owed and serviced back to back once the grant returns. A request left waiting past a slack limit raises an overdue flag.

If the memory sees no row-strobe activity for longer than the idle limit, the block drops `ready_o` and repeats the wake-up burst. Activity comes either from its own cycles or from accesses reported on `activity_i`. The pause, wake-up count, interval, pulse widths, slack and idle limit are all parameters expressed in clock cycles.

Top module: `dram_rfsh_sched`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ras_n_o` and `cas_n_o` are 1, `req_o`, `ready_o` and `overdue_o` are 0, and `row_addr_o` and `owed_o` are 0.
- R2: During the first PAUSE_CYC cycles after reset no row strobe falls.
- R3: After the pause exactly WAKE_CNT row-strobe cycles run before `ready_o` rises, and `ready_o` is 0 until then.
- R4: Every row-strobe low pulse lasts exactly RAS_LO_CYC cycles. The strobe then stays high at least RAS_PRE_CYC cycles before it falls again. `cas_n_o` is 1 at all times.
- R5: `row_addr_o` is {0, row counter}, so bit 7 is always 0. It is stable while the strobe is low. It advances by one after every completed cycle, wake-up cycles included, and wraps from 127 to 0.
- R6: Once ready, with the grant always given, exactly one refresh starts per INTERVAL_CYC cycles.
- R7: The row strobe falls only in the cycle after one in which `req_o` and `grant_i` were both 1.
- R8: Each interval that elapses adds one to `owed_o`, which saturates. Each completed refresh removes one. When the grant returns, the owed refreshes run back to back until `owed_o` is 0.
- R9: `overdue_o` rises once `req_o` has waited about SLACK_CYC cycles without a grant. It is 0 once the pending work has been serviced.
- R10: If IDLE_CYC cycles pass in the ready state without a cycle starting or `activity_i` pulsing, `ready_o` falls. WAKE_CNT wake-up cycles then run before `ready_o` rises again.
- R11: A pulse on `activity_i` restarts the idle count, so periodic activity keeps `ready_o` high even with the grant withheld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| grant_i | input | 1 | Cycle controller lets the scheduler start a cycle |
| activity_i | input | 1 | One-cycle pulse for a row-strobe access made by another agent |
| req_o | output | 1 | A wake-up or refresh cycle is pending |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, held high |
| row_addr_o | output | ADDR_BITS | Row address; the top bit is 0 |
| ready_o | output | 1 | Wake-up complete; memory usable |
| overdue_o | output | 1 | Request has waited past the slack limit |
| owed_o | output | OWED_W | Number of refreshes owed |

## Verification
The assertions assume that `grant_i` is given only to a raised request and may be withheld for any length of time. They also assume that `activity_i` is a short pulse unrelated to the scheduler's own cycles. The stimulus changes both inputs only between clock edges. It withholds the grant only for chosen multiples of the interval or the idle limit. The parameters are kept such that the idle limit is longer than the interval, and the interval is longer than one full strobe cycle, so every window the bench counts over has an exact expected count.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;
  typedef enum logic [1:0] {
    ST_PAUSE = 2'd0,
    ST_WAKE  = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/rfsh_span_timer.sv
// Counts enabled cycles; one-cycle hit after LIMIT cycles, then restarts.
module rfsh_span_timer #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr || !en) begin
      cnt_q <= '0;
      hit   <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      hit   <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      hit   <= 1'b0;
    end
  end
endmodule

// File: rtl/ras_pulse_engine.sv
// One row-strobe-only cycle: LO cycles low, then PRE cycles high, then done.
module ras_pulse_engine #(
  parameter int LO  = 30,
  parameter int PRE = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ras_n,
  output logic busy,
  output logic done
);
  localparam int MAXW = (LO > PRE) ? LO : PRE;
  localparam int CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] LO_LAST  = CW'(LO - 1);
  localparam logic [CW-1:0] PRE_LAST = CW'(PRE - 1);

  logic [CW-1:0] cnt_q;
  logic          low_phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_n       <= 1'b1;
      busy        <= 1'b0;
      done        <= 1'b0;
      low_phase_q <= 1'b0;
      cnt_q       <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy        <= 1'b1;
          ras_n       <= 1'b0;
          low_phase_q <= 1'b1;
          cnt_q       <= LO_LAST;
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (low_phase_q) begin
        ras_n       <= 1'b1;
        low_phase_q <= 1'b0;
        cnt_q       <= PRE_LAST;
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dram_rfsh_sched.sv
module dram_rfsh_sched
  import dram_rfsh_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int WAKE_CNT     = 8,
  parameter int INTERVAL_CYC = 3120,
  parameter int RAS_LO_CYC   = 30,
  parameter int RAS_PRE_CYC  = 20,
  parameter int SLACK_CYC    = 600,
  parameter int IDLE_CYC     = 400000,
  parameter int ROW_BITS     = 7,
  parameter int ADDR_BITS    = 8,
  parameter int OWED_W       = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 grant_i,
  input  logic                 activity_i,
  output logic                 req_o,
  output logic                 ras_n_o,
  output logic                 cas_n_o,
  output logic [ADDR_BITS-1:0] row_addr_o,
  output logic                 ready_o,
  output logic                 overdue_o,
  output logic [OWED_W-1:0]    owed_o
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int WW = $clog2(WAKE_CNT + 1);
  localparam int SW = $clog2(SLACK_CYC + 1);
  localparam logic [PW-1:0]     PAUSE_LAST = PW'(PAUSE_CYC - 1);
  localparam logic [WW-1:0]     WAKE_INIT  = WW'(WAKE_CNT);
  localparam logic [SW-1:0]     SLACK_LAST = SW'(SLACK_CYC - 1);
  localparam logic [SW-1:0]     SLACK_MAX  = '1;
  localparam logic [OWED_W-1:0] OWED_MAX   = '1;

  seq_state_t        state_q, state_d;
  logic [PW-1:0]     pause_q;
  logic [WW-1:0]     wake_q, wake_d;
  logic [OWED_W-1:0] owed_q;
  logic [ROW_BITS-1:0] row_q;
  logic [SW-1:0]     wait_q;
  logic              req_q, overdue_q, ready_q, cas_n_q;
  logic              eng_busy, eng_done, eng_ras_n;
  logic              tick, stale, start, pend, in_run;

  assign in_run = (state_q == ST_RUN);
  assign start  = req_q & grant_i & ~eng_busy;

  always_comb begin
    unique case (state_q)
      ST_WAKE: pend = (wake_q != '0);
      ST_RUN:  pend = (owed_q != '0);
      default: pend = 1'b0;
    endcase
  end

  rfsh_span_timer #(.LIMIT(INTERVAL_CYC)) interval_i (
    .clk(clk), .rst(rst), .en(in_run), .clr(1'b0), .hit(tick)
  );

  rfsh_span_timer #(.LIMIT(IDLE_CYC)) idle_i (
    .clk(clk), .rst(rst), .en(in_run), .clr(start | activity_i), .hit(stale)
  );

  ras_pulse_engine #(.LO(RAS_LO_CYC), .PRE(RAS_PRE_CYC)) engine_i (
    .clk(clk), .rst(rst), .start(start),
    .ras_n(eng_ras_n), .busy(eng_busy), .done(eng_done)
  );

  // Sequencing: pause -> wake-up burst -> run, back to wake-up on idle.
  always_comb begin
    state_d = state_q;
    wake_d  = wake_q;
    unique case (state_q)
      ST_PAUSE: begin
        if (pause_q == PAUSE_LAST) begin
          state_d = ST_WAKE;
          wake_d  = WAKE_INIT;
        end
      end
      ST_WAKE: begin
        if (eng_done && wake_q != '0) begin
          wake_d = wake_q - 1'b1;
          if (wake_q == WW'(1)) state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (stale) begin
          state_d = ST_WAKE;
          wake_d  = WAKE_INIT;
        end
      end
      default: state_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_PAUSE;
      pause_q   <= '0;
      wake_q    <= '0;
      owed_q    <= '0;
      row_q     <= '0;
      wait_q    <= '0;
      req_q     <= 1'b0;
      overdue_q <= 1'b0;
      ready_q   <= 1'b0;
      cas_n_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
      ready_q <= (state_d == ST_RUN);
      cas_n_q <= 1'b1;
      if (state_q == ST_PAUSE) pause_q <= pause_q + 1'b1;

      // owed refreshes: one per interval in, one per completed refresh out
      if (tick && !(eng_done && in_run)) begin
        if (owed_q != OWED_MAX) owed_q <= owed_q + 1'b1;
      end else if (!tick && eng_done && in_run) begin
        if (owed_q != '0) owed_q <= owed_q - 1'b1;
      end

      if (eng_done) row_q <= row_q + 1'b1;

      req_q <= pend & ~eng_busy & ~start & ~eng_done;

      if (!req_q || start) wait_q <= '0;
      else if (wait_q != SLACK_MAX) wait_q <= wait_q + 1'b1;
      overdue_q <= req_q & ~start & (wait_q >= SLACK_LAST);
    end
  end

  assign req_o      = req_q;
  assign ras_n_o    = eng_ras_n;
  assign cas_n_o    = cas_n_q;
  assign row_addr_o = {{(ADDR_BITS - ROW_BITS){1'b0}}, row_q};
  assign ready_o    = ready_q;
  assign overdue_o  = overdue_q;
  assign owed_o     = owed_q;
endmodule

// File: rtl/dram_rfsh_sched_chk.sv
module dram_rfsh_sched_chk #(
  parameter int RAS_LO_CYC  = 30,
  parameter int RAS_PRE_CYC = 20,
  parameter int ADDR_BITS   = 8,
  parameter int OWED_W      = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 grant_i,
  input logic                 req_o,
  input logic                 ras_n_o,
  input logic                 cas_n_o,
  input logic [ADDR_BITS-1:0] row_addr_o,
  input logic                 overdue_o,
  input logic [OWED_W-1:0]    owed_o
);
  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      lo_cnt <= ras_n_o ? 16'd0 : lo_cnt + 16'd1;
      hi_cnt <= !ras_n_o ? 16'd0 : ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1);
    end
  end

  assert_cas_high_R4: assert property (@(posedge clk) disable iff (rst)
    cas_n_o);

  assert_low_bound_R4: assert property (@(posedge clk) disable iff (rst)
    !ras_n_o |-> (lo_cnt < 16'(RAS_LO_CYC)));

  assert_low_exact_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n_o) |-> ($past(lo_cnt) == 16'(RAS_LO_CYC - 1)));

  assert_precharge_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n_o) |-> ($past(hi_cnt) >= 16'(RAS_PRE_CYC - 1)));

  assert_row_top_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !row_addr_o[ADDR_BITS-1]);

  assert_row_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (!ras_n_o && $past(!ras_n_o)) |-> $stable(row_addr_o));

  assert_grant_start_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n_o) |-> $past(req_o && grant_i));

  assert_owed_step_R8: assert property (@(posedge clk) disable iff (rst)
    (owed_o > $past(owed_o)) |-> (owed_o == $past(owed_o) + 1'b1));

  assert_overdue_pending_R9: assert property (@(posedge clk) disable iff (rst)
    overdue_o |-> req_o);
endmodule

bind dram_rfsh_sched dram_rfsh_sched_chk #(
  .RAS_LO_CYC(RAS_LO_CYC), .RAS_PRE_CYC(RAS_PRE_CYC),
  .ADDR_BITS(ADDR_BITS), .OWED_W(OWED_W)
) chk_i (
  .clk(clk), .rst(rst), .grant_i(grant_i), .req_o(req_o), .ras_n_o(ras_n_o),
  .cas_n_o(cas_n_o), .row_addr_o(row_addr_o), .overdue_o(overdue_o),
  .owed_o(owed_o)
);

// File: tb/dram_rfsh_sched_tb_top.sv
`timescale 1ns/1ps
module dram_rfsh_sched_tb_top;
  localparam int P_PAUSE = 40;
  localparam int P_WAKE  = 8;
  localparam int P_INTV  = 60;
  localparam int P_LO    = 4;
  localparam int P_PRE   = 3;
  localparam int P_SLACK = 10;
  localparam int P_IDLE  = 300;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       grant = 1'b0;
  logic       activity = 1'b0;
  logic       req, ras_n, cas_n, ready, overdue;
  logic [7:0] row;
  logic [3:0] owed;

  int n_checks = 0;
  int n_fail   = 0;
  int falls    = 0;
  int bad_low = 0, bad_pre = 0, bad_cas = 0, bad_top = 0, bad_stab = 0, bad_gnt = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  dram_rfsh_sched #(
    .PAUSE_CYC(P_PAUSE), .WAKE_CNT(P_WAKE), .INTERVAL_CYC(P_INTV),
    .RAS_LO_CYC(P_LO), .RAS_PRE_CYC(P_PRE), .SLACK_CYC(P_SLACK),
    .IDLE_CYC(P_IDLE), .ROW_BITS(7), .ADDR_BITS(8), .OWED_W(4)
  ) dut_i (
    .clk(clk), .rst(rst), .grant_i(grant), .activity_i(activity),
    .req_o(req), .ras_n_o(ras_n), .cas_n_o(cas_n), .row_addr_o(row),
    .ready_o(ready), .overdue_o(overdue), .owed_o(owed)
  );

  // Port monitor sampled on falling edges.
  logic prev_ras = 1'b1, prev_req = 1'b0, prev_gnt = 1'b0;
  logic [7:0] prev_row = '0;
  int lo_len = 0, hi_len = 1000;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (cas_n !== 1'b1) bad_cas++;
      if (row[7] !== 1'b0) bad_top++;
      if (prev_ras && !ras_n) begin
        falls++;
        if (!(prev_req && prev_gnt)) bad_gnt++;
        if (hi_len < P_PRE) bad_pre++;
        lo_len = 1;
      end else if (!ras_n) begin
        lo_len++;
        if (row != prev_row) bad_stab++;
      end
      if (!prev_ras && ras_n) begin
        if (lo_len != P_LO) bad_low++;
        hi_len = 1;
      end else if (ras_n) hi_len++;
    end
    prev_ras = ras_n; prev_req = req; prev_gnt = grant; prev_row = row;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_fall();
    int f0 = falls;
    for (int i = 0; i < 2000 && falls == f0; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    cycles(4);
    chk(ras_n && cas_n && !req && !ready && !overdue && row == 0 && owed == 0,
        "R1 reset outputs", {ras_n, cas_n, req, ready, overdue}, 5'b11000);
    rst = 1'b0;
    @(negedge clk);
    chk(ras_n && !req && !ready && row == 0, "R1 first cycle after reset",
        {ras_n, req, ready}, 3'b100);
  endtask

  task automatic t_init();
    int first = -1, t = 1, wake_falls;
    int f0 = falls;
    while (!ready && t < 2000) begin
      if (first < 0 && falls != f0) first = t;
      @(negedge clk);
      t++;
    end
    chk(first >= P_PAUSE, "R2 no strobe during pause", first, P_PAUSE);
    wake_falls = falls - f0;
    chk(wake_falls == P_WAKE, "R3 wake-up cycles before ready", wake_falls, P_WAKE);
    chk(ready == 1'b1, "R3 ready after wake-up", ready, 1);
    cycles(3);
    chk(row == 8'(P_WAKE), "R5 row advanced by wake-up cycles", row, P_WAKE);
  endtask

  task automatic t_interval();
    int f0;
    logic [7:0] r0;
    cycles(P_INTV);
    f0 = falls; r0 = row;
    cycles(10 * P_INTV);
    chk(falls - f0 == 10, "R6 one refresh per interval", falls - f0, 10);
    chk(8'(row - r0) == 8'd10, "R5 row increments per refresh", row - r0, 10);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 20000 && row != 8'd127; i++) @(negedge clk);
    chk(row == 8'd127, "R5 reach last row", row, 127);
    wait_fall();
    cycles(20);
    chk(row == 8'd0, "R5 wrap to row 0", row, 0);
  endtask

  task automatic t_owed();
    int f0;
    wait_fall();
    grant = 1'b0;
    cycles(190);
    chk(owed == 4'd3, "R8 owed count while grant withheld", owed, 3);
    chk(overdue == 1'b1, "R9 overdue after slack", overdue, 1);
    f0 = falls;
    grant = 1'b1;
    cycles(40);
    chk(falls - f0 == 3, "R8 owed refreshes serviced", falls - f0, 3);
    chk(owed == 4'd0, "R8 owed drained", owed, 0);
    chk(overdue == 1'b0, "R9 overdue cleared", overdue, 0);
  endtask

  task automatic t_activity();
    int low_seen = 0;
    wait_fall();
    grant = 1'b0;
    for (int i = 0; i < 350; i++) begin
      activity = (i % 100 == 50);
      @(negedge clk);
      if (!ready) low_seen++;
    end
    activity = 1'b0;
    chk(low_seen == 0, "R11 activity keeps ready high", low_seen, 0);
    grant = 1'b1;
    cycles(150);
    chk(owed == 4'd0, "R8 backlog drained after activity window", owed, 0);
  endtask

  task automatic t_idle();
    int f0, t = 0;
    wait_fall();
    grant = 1'b0;
    cycles(350);
    chk(ready == 1'b0, "R10 ready drops after idle limit", ready, 0);
    f0 = falls;
    grant = 1'b1;
    while (!ready && t < 1000) begin
      @(negedge clk);
      t++;
    end
    chk(falls - f0 == P_WAKE, "R10 wake-up repeated", falls - f0, P_WAKE);
    cycles(150);
  endtask

  task automatic t_monitor();
    chk(bad_low == 0, "R4 low width", bad_low, 0);
    chk(bad_pre == 0, "R4 precharge width", bad_pre, 0);
    chk(bad_cas == 0, "R4 column strobe high", bad_cas, 0);
    chk(bad_top == 0, "R5 address top bit zero", bad_top, 0);
    chk(bad_stab == 0, "R5 row stable while low", bad_stab, 0);
    chk(bad_gnt == 0, "R7 start only after request and grant", bad_gnt, 0);
  endtask

  initial begin
    fork
      begin
        grant = 1'b1;
        t_reset();
        t_init();
        t_interval();
        t_wrap();
        t_owed();
        t_activity();
        t_idle();
        t_monitor();
      end
      begin
        while (cyc < 150000) @(negedge clk);
        chk(1'b0, "watchdog expired", cyc, 150000);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule